// File: doc/BRIEF.md
# Memory Region Permission Checker

This block decides whether one memory access may proceed under a set of protection entries. Every entry holds a configuration byte and a word-granular address. From these the block derives an inclusive byte range per entry, using one of three region shapes: a top-of-range boundary paired with the entry below it, a single aligned word, or a naturally aligned power-of-two block. The access is described by its first byte address, its size in bytes, the permissions it asks for (read, write, execute) and whether the requester runs in machine mode.

Entries are searched from the lowest index upward. The first active entry that touches the access decides the outcome. If it holds the whole access, its permissions apply. If it holds only one end, the access is refused. Two security controls change the rules. A lockdown control replaces the plain permission bits with a fixed sixteen-way mapping of lock, read, write and execute, and that mapping differs for machine mode. An allow-list control refuses every access that no entry covers. Each request presented with `req_valid` produces its grant decision and allowed mask one clock later.

Top module: `pmp_checker`

## Requirements
- R1: Configuration byte layout: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 region shape (0 off, 1 top-of-range, 2 single word, 3 power-of-two block), bit 7 lock. An entry with shape 0 never matches and never refuses an access.
- R2: A top-of-range entry covers bytes from four times the previous entry's address (zero for entry 0) up to four times its own address minus one, inclusive.
- R3: A single-word entry covers the four bytes that start at four times its address.
- R4: A power-of-two entry whose address ends in t one-bits covers an aligned block of 2^(t+3) bytes that contains four times its address.
- R5: The lowest-indexed active entry that touches the access decides the result. Higher entries are then ignored.
- R6: If the deciding entry holds exactly one of the first byte and the last byte (first + size - 1, where size is 1 to 8), the access is refused and the allowed mask is zero.
- R7: With lockdown off, a matching entry allows its own read/write/execute bits, except that machine mode on an unlocked entry is allowed all three.
- R8: With lockdown on, in machine mode the index {lock,read,write,execute} (lock as MSB) allows read+write for 2, 3 and 14; execute for 9 and 10; read+execute for 11 and 13; read for 12 and 15; nothing otherwise.
- R9: With lockdown on, outside machine mode the same index allows execute for 1, 10 and 11; read for 2, 4 and 15; read+write for 3 and 6; read+execute for 5; all three for 7; nothing otherwise.
- R10: With no matching entry: the allow-list control refuses everything (mask 0). Otherwise lockdown grants only a machine-mode access that asks no execute, with mask read+write, and refuses anything else with mask 0. Otherwise machine mode is granted all three and other modes are refused with mask 0.
- R11: When an entry fully matches, the grant is set only if every requested permission bit is in the allowed mask.
- R12: Reset clears rsp_valid, rsp_grant and rsp_allow. A request with req_valid high yields its result with rsp_valid high on the next clock. Without req_valid, rsp_valid falls and the result is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe; captures the decision |
| req_addr | input | AW | First byte address of the access |
| req_size | input | 4 | Access size in bytes, 1 to 8 |
| req_perm | input | 3 | Requested permissions {X,W,R} |
| req_mmode | input | 1 | Requester runs in machine mode |
| sec_mml | input | 1 | Lockdown control |
| sec_mmwp | input | 1 | Allow-list (deny when unmatched) control |
| ent_cfg | input | NE*8 | Configuration bytes, entry i at bits 8i+7:8i |
| ent_addr | input | NE*(AW-2) | Entry word addresses, entry i at slice i |
| rsp_valid | output | 1 | Result valid |
| rsp_grant | output | 1 | Access allowed |
| rsp_allow | output | 3 | Allowed permission mask {X,W,R} |

## Verification
The assertions assume that entry configuration, addresses and security controls stay fixed in the cycle a request is captured, and that req_size stays within 1 to 8. The bench changes those inputs only on the falling edge together with the request, and draws sizes only from that range. The random stimulus keeps entry addresses and request addresses in a small window so that overlaps, partial hits and priority conflicts happen often. Directed cases cover every lockdown table index in both modes.

// File: rtl/pmpc_pkg.sv
package pmpc_pkg;

  typedef enum logic [1:0] {
    SHAPE_OFF   = 2'd0,
    SHAPE_TOR   = 2'd1,
    SHAPE_WORD  = 2'd2,
    SHAPE_BLOCK = 2'd3
  } shape_e;

  localparam int BIT_RD   = 0;
  localparam int BIT_WR   = 1;
  localparam int BIT_EX   = 2;
  localparam int BIT_LOCK = 7;

  localparam logic [2:0] P_NONE = 3'b000;
  localparam logic [2:0] P_R    = 3'b001;
  localparam logic [2:0] P_RW   = 3'b011;
  localparam logic [2:0] P_X    = 3'b100;
  localparam logic [2:0] P_RX   = 3'b101;
  localparam logic [2:0] P_RWX  = 3'b111;

  // lockdown mapping, index = {lock, read, write, execute}
  function automatic logic [2:0] lockdown_map(input logic [3:0] idx, input logic mmode);
    logic [2:0] res;
    res = P_NONE;
    if (mmode) begin
      case (idx)
        4'd2, 4'd3, 4'd14: res = P_RW;
        4'd9, 4'd10:       res = P_X;
        4'd11, 4'd13:      res = P_RX;
        4'd12, 4'd15:      res = P_R;
        default:           res = P_NONE;
      endcase
    end else begin
      case (idx)
        4'd1, 4'd10, 4'd11: res = P_X;
        4'd2, 4'd4, 4'd15:  res = P_R;
        4'd3, 4'd6:         res = P_RW;
        4'd5:               res = P_RX;
        4'd7:               res = P_RWX;
        default:            res = P_NONE;
      endcase
    end
    return res;
  endfunction

endpackage

// File: rtl/pmpc_region.sv
module pmpc_region
  import pmpc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [1:0]    shape,
  input  logic [AW-3:0] prev_addr,
  input  logic [AW-3:0] this_addr,
  output logic [AW-1:0] lo,
  output logic [AW-1:0] hi
);
  logic [AW-1:0] ones_ext;
  logic [AW-1:0] ones_inc;
  logic [AW-1:0] base;

  assign ones_ext = {this_addr, 2'b11};
  assign ones_inc = ones_ext + {{(AW-1){1'b0}}, 1'b1};
  assign base     = {this_addr, 2'b00};

  always_comb begin
    lo = '0;
    hi = '0;
    case (shape_e'(shape))
      SHAPE_TOR: begin
        lo = {prev_addr, 2'b00};
        hi = base - {{(AW-1){1'b0}}, 1'b1};
      end
      SHAPE_WORD: begin
        lo = base;
        hi = base | {{(AW-2){1'b0}}, 2'b11};
      end
      SHAPE_BLOCK: begin
        lo = ones_ext & ones_inc;
        hi = ones_ext | ones_inc;
      end
      default: begin
        lo = '0;
        hi = '0;
      end
    endcase
  end
endmodule

// File: rtl/pmpc_perm.sv
module pmpc_perm
  import pmpc_pkg::*;
(
  input  logic [7:0] cfg,
  input  logic       mmode,
  input  logic       mml,
  output logic [2:0] allow
);
  logic       locked;
  logic [2:0] own;
  logic [3:0] idx;

  assign locked = cfg[BIT_LOCK];
  assign own    = {cfg[BIT_EX], cfg[BIT_WR], cfg[BIT_RD]};
  assign idx    = {locked, cfg[BIT_RD], cfg[BIT_WR], cfg[BIT_EX]};

  always_comb begin
    if (mml)
      allow = lockdown_map(idx, mmode);
    else if (!mmode || locked)
      allow = own;
    else
      allow = P_RWX;
  end
endmodule

// File: rtl/pmpc_first.sv
module pmpc_first #(
  parameter int NE = 8,
  localparam int IW = (NE > 1) ? $clog2(NE) : 1
) (
  input  logic [NE-1:0] hits,
  output logic          any,
  output logic [IW-1:0] sel
);
  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int i = NE - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any = 1'b1;
        sel = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
  import pmpc_pkg::*;
#(
  parameter int NE = 8,
  parameter int AW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [AW-1:0]      req_addr,
  input  logic [3:0]         req_size,
  input  logic [2:0]         req_perm,
  input  logic               req_mmode,
  input  logic               sec_mml,
  input  logic               sec_mmwp,
  input  logic [NE*8-1:0]    ent_cfg,
  input  logic [NE*(AW-2)-1:0] ent_addr,
  output logic               rsp_valid,
  output logic               rsp_grant,
  output logic [2:0]         rsp_allow
);
  localparam int EAW = AW - 2;
  localparam int IW  = (NE > 1) ? $clog2(NE) : 1;

  logic [AW-1:0] last_byte;
  logic [NE-1:0] full_hit;
  logic [NE-1:0] part_hit;
  logic [NE-1:0] touch;
  logic [2:0]    ent_allow [NE];
  logic          any_hit;
  logic [IW-1:0] first_idx;
  logic          grant_d;
  logic [2:0]    allow_d;

  assign last_byte = req_addr + {{(AW-4){1'b0}}, req_size} - {{(AW-1){1'b0}}, 1'b1};

  for (genvar g = 0; g < NE; g++) begin : g_ent
    logic [7:0]     cfg;
    logic [EAW-1:0] prev;
    logic [AW-1:0]  lo;
    logic [AW-1:0]  hi;
    logic           in_first;
    logic           in_last;
    logic           active;

    assign cfg = ent_cfg[g*8 +: 8];
    if (g == 0) begin : g_base
      assign prev = '0;
    end else begin : g_chain
      assign prev = ent_addr[(g-1)*EAW +: EAW];
    end

    pmpc_region #(.AW(AW)) u_region (
      .shape     (cfg[4:3]),
      .prev_addr (prev),
      .this_addr (ent_addr[g*EAW +: EAW]),
      .lo        (lo),
      .hi        (hi)
    );

    pmpc_perm u_perm (
      .cfg   (cfg),
      .mmode (req_mmode),
      .mml   (sec_mml),
      .allow (ent_allow[g])
    );

    assign active      = (cfg[4:3] != SHAPE_OFF);
    assign in_first    = (req_addr >= lo) && (req_addr <= hi);
    assign in_last     = (last_byte >= lo) && (last_byte <= hi);
    assign full_hit[g] = active && in_first && in_last;
    assign part_hit[g] = active && (in_first ^ in_last);
    assign touch[g]    = full_hit[g] | part_hit[g];
  end

  pmpc_first #(.NE(NE)) u_first (
    .hits (touch),
    .any  (any_hit),
    .sel  (first_idx)
  );

  always_comb begin
    grant_d = 1'b0;
    allow_d = P_NONE;
    if (any_hit) begin
      if (!part_hit[first_idx]) begin
        allow_d = ent_allow[first_idx];
        grant_d = ((req_perm & ~allow_d) == 3'b000);
      end
    end else if (sec_mmwp) begin
      grant_d = 1'b0;
      allow_d = P_NONE;
    end else if (sec_mml) begin
      if (req_mmode && !req_perm[BIT_EX]) begin
        grant_d = 1'b1;
        allow_d = P_RW;
      end
    end else if (req_mmode) begin
      grant_d = 1'b1;
      allow_d = P_RWX;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      rsp_allow <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_grant <= grant_d;
        rsp_allow <= allow_d;
      end
    end
  end
endmodule

// File: rtl/pmp_checker_sva.sv
module pmp_checker_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_perm,
  input logic       req_mmode,
  input logic       sec_mml,
  input logic       rsp_valid,
  input logic       rsp_grant,
  input logic [2:0] rsp_allow
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R12
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R12
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_grant) && $stable(rsp_allow))); // R12
  AST_GRANT_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_grant) |-> (($past(req_perm) & ~rsp_allow) == 3'b000)); // R11
  AST_MML_M_NO_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(sec_mml) && $past(req_mmode)) |-> (rsp_allow != 3'b111)); // R8
  AST_MML_W_WITH_R: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(sec_mml) && rsp_allow[1]) |-> rsp_allow[0]); // R9
endmodule

bind pmp_checker pmp_checker_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_perm  (req_perm),
  .req_mmode (req_mmode),
  .sec_mml   (sec_mml),
  .rsp_valid (rsp_valid),
  .rsp_grant (rsp_grant),
  .rsp_allow (rsp_allow)
);

// File: tb/sim_pmp_checker.sv
module sim_pmp_checker;
  localparam int NE = 8;
  localparam int AW = 32;
  localparam int EAW = AW - 2;
  localparam time CLK_PERIOD = 10ns;
  localparam longint unsigned M32 = 64'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [AW-1:0] req_addr;
  logic [3:0] req_size;
  logic [2:0] req_perm;
  logic req_mmode, sec_mml, sec_mmwp;
  logic [NE*8-1:0] ent_cfg;
  logic [NE*EAW-1:0] ent_addr;
  logic rsp_valid, rsp_grant;
  logic [2:0] rsp_allow;

  logic [7:0]     cfg_a [NE];
  logic [EAW-1:0] adr_a [NE];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NE; i++) begin
      ent_cfg[i*8 +: 8]     = cfg_a[i];
      ent_addr[i*EAW +: EAW] = adr_a[i];
    end
  end

  pmp_checker #(.NE(NE), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_perm(req_perm), .req_mmode(req_mmode),
    .sec_mml(sec_mml), .sec_mmwp(sec_mmwp), .ent_cfg(ent_cfg), .ent_addr(ent_addr),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_allow(rsp_allow)
  );

  function automatic logic [2:0] ref_table(input logic [3:0] ix, input logic mm);
    if (mm) begin
      case (ix)
        4'd2, 4'd3, 4'd14: return 3'b011;
        4'd9, 4'd10:       return 3'b100;
        4'd11, 4'd13:      return 3'b101;
        4'd12, 4'd15:      return 3'b001;
        default:           return 3'b000;
      endcase
    end
    case (ix)
      4'd1, 4'd10, 4'd11: return 3'b100;
      4'd2, 4'd4, 4'd15:  return 3'b001;
      4'd3, 4'd6:         return 3'b011;
      4'd5:               return 3'b101;
      4'd7:               return 3'b111;
      default:            return 3'b000;
    endcase
  endfunction

  // returns {grant, allow}
  function automatic logic [3:0] ref_model(input logic [31:0] a, input logic [3:0] sz,
      input logic [2:0] p, input logic mm, input logic mml, input logic mmwp);
    longint unsigned first, last, lo, hi, span;
    int t;
    logic fi, la;
    logic [2:0] al;
    first = 64'(a);
    last  = (first + 64'(sz) - 1) & M32;
    for (int i = 0; i < NE; i++) begin
      lo = 0; hi = 0;
      if (cfg_a[i][4:3] == 2'd0) continue;
      if (cfg_a[i][4:3] == 2'd1) begin
        lo = (i == 0) ? 0 : (64'(adr_a[i-1]) << 2);
        hi = ((64'(adr_a[i]) << 2) - 1) & M32;
      end else if (cfg_a[i][4:3] == 2'd2) begin
        lo = 64'(adr_a[i]) << 2;
        hi = lo + 3;
      end else begin
        t = 0;
        while (t < EAW && adr_a[i][t]) t++;
        span = 64'd1 << (t + 3);
        lo = (64'(adr_a[i]) << 2) & ~(span - 1);
        hi = (lo + span - 1) & M32;
      end
      fi = (first >= lo) && (first <= hi);
      la = (last >= lo) && (last <= hi);
      if (fi != la) return 4'b0000;
      if (fi) begin
        if (mml)
          al = ref_table({cfg_a[i][7], cfg_a[i][0], cfg_a[i][1], cfg_a[i][2]}, mm);
        else if (!mm || cfg_a[i][7])
          al = cfg_a[i][2:0];
        else
          al = 3'b111;
        return {((p & ~al) == 3'b000), al};
      end
    end
    if (mmwp) return 4'b0000;
    if (mml) return (mm && !p[2]) ? 4'b1011 : 4'b0000;
    return mm ? 4'b1111 : 4'b0000;
  endfunction

  task automatic clear_entries();
    for (int i = 0; i < NE; i++) begin
      cfg_a[i] = 8'h00;
      adr_a[i] = '0;
    end
  endtask

  task automatic check(input string tag, input logic [31:0] a, input logic [3:0] sz,
      input logic [2:0] p, input logic mm);
    logic [3:0] exp;
    @(negedge clk);
    req_addr = a; req_size = sz; req_perm = p; req_mmode = mm; req_valid = 1'b1;
    exp = ref_model(a, sz, p, mm, sec_mml, sec_mmwp);
    @(negedge clk);
    req_valid = 1'b0;
    checks++;
    if (rsp_valid !== 1'b1 || rsp_grant !== exp[3] || rsp_allow !== exp[2:0]) begin
      errors++;
      $display("FAIL %s addr=%h size=%0d perm=%b mm=%b: actual v=%b g=%b a=%b expected v=1 g=%b a=%b",
               tag, a, sz, p, mm, rsp_valid, rsp_grant, rsp_allow, exp[3], exp[2:0]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R12: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic g0;
    logic [2:0] a0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = 4'd1; req_perm = '0;
    req_mmode = 1'b0; sec_mml = 1'b0; sec_mmwp = 1'b0;
    clear_entries();
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_grant !== 1'b0 || rsp_allow !== 3'b000) begin
      errors++;
      $display("FAIL R12 reset: actual v=%b g=%b a=%b expected 0 0 000", rsp_valid, rsp_grant, rsp_allow);
    end
    rst_n = 1'b1;

    // no entries: default rules
    check("R10 m no match", 32'h100, 4'd4, 3'b111, 1'b1);
    check("R10 user no match", 32'h100, 4'd4, 3'b001, 1'b0);
    sec_mmwp = 1'b1;
    check("R10 allow-list m", 32'h100, 4'd4, 3'b001, 1'b1);
    sec_mmwp = 1'b0; sec_mml = 1'b1;
    check("R10 lockdown m read", 32'h100, 4'd4, 3'b001, 1'b1);
    check("R10 lockdown m exec", 32'h100, 4'd4, 3'b100, 1'b1);
    check("R10 lockdown user", 32'h100, 4'd4, 3'b001, 1'b0);
    sec_mml = 1'b0;

    // single word at 0x100, read only
    cfg_a[0] = 8'h11; adr_a[0] = 30'h40;
    check("R3 word hit", 32'h100, 4'd4, 3'b001, 1'b0);
    check("R3 word miss", 32'h104, 4'd1, 3'b001, 1'b0);
    check("R6 word partial", 32'h102, 4'd4, 3'b001, 1'b0);
    check("R11 word write refused", 32'h100, 4'd1, 3'b010, 1'b0);

    // off entry with all bits never matches
    clear_entries(); cfg_a[0] = 8'h07; adr_a[0] = 30'h40;
    check("R1 off entry", 32'h100, 4'd4, 3'b001, 1'b0);

    // top-of-range entry 1 over 0x100..0x1FF
    clear_entries(); adr_a[0] = 30'h40; cfg_a[1] = 8'h0B; adr_a[1] = 30'h80;
    check("R2 tor inside", 32'h1F8, 4'd8, 3'b010, 1'b0);
    check("R6 tor partial", 32'h1FC, 4'd8, 3'b001, 1'b0);
    check("R2 tor above", 32'h200, 4'd1, 3'b001, 1'b0);
    check("R2 tor below", 32'h0FF, 4'd1, 3'b001, 1'b0);
    clear_entries(); cfg_a[0] = 8'h0C; adr_a[0] = 30'h10;
    check("R2 tor from zero", 32'h0, 4'd4, 3'b100, 1'b0);

    // power-of-two block of 64 bytes at 0x400
    clear_entries(); cfg_a[2] = 8'h19; adr_a[2] = 30'h107;
    check("R4 block top", 32'h43C, 4'd4, 3'b001, 1'b0);
    check("R4 block base", 32'h400, 4'd1, 3'b001, 1'b0);
    check("R4 block after", 32'h440, 4'd1, 3'b001, 1'b0);

    // priority: word entry 0 read only, block entry 1 everything
    clear_entries(); cfg_a[0] = 8'h11; adr_a[0] = 30'h40; cfg_a[1] = 8'h1F; adr_a[1] = 30'h43;
    check("R5 low entry decides", 32'h100, 4'd4, 3'b010, 1'b0);
    check("R5 high entry used", 32'h108, 4'd4, 3'b010, 1'b0);

    // machine mode without lockdown
    clear_entries(); cfg_a[0] = 8'h11; adr_a[0] = 30'h40;
    check("R7 m unlocked", 32'h100, 4'd4, 3'b110, 1'b1);
    cfg_a[0] = 8'h91;
    check("R7 m locked", 32'h100, 4'd4, 3'b010, 1'b1);

    // lockdown tables, every index in both modes
    sec_mml = 1'b1;
    for (int ix = 0; ix < 16; ix++) begin
      for (int m = 0; m < 2; m++) begin
        logic [3:0] iv;
        iv = 4'(ix);
        clear_entries();
        cfg_a[0] = {iv[3], 2'b00, 2'b10, iv[0], iv[1], iv[2]};
        adr_a[0] = 30'h40;
        check(m ? "R8 lockdown m table" : "R9 lockdown user table", 32'h100, 4'd4, 3'b001, m[0]);
      end
    end
    sec_mml = 1'b0;

    // hold when idle
    clear_entries();
    check("R12 capture", 32'h100, 4'd4, 3'b001, 1'b1);
    g0 = rsp_grant; a0 = rsp_allow;
    @(negedge clk);
    req_mmode = 1'b0; req_perm = 3'b111;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_grant !== g0 || rsp_allow !== a0) begin
      errors++;
      $display("FAIL R12 hold: actual v=%b g=%b a=%b expected v=0 g=%b a=%b",
               rsp_valid, rsp_grant, rsp_allow, g0, a0);
    end

    // random mix
    for (int n = 0; n < 600; n++) begin
      for (int i = 0; i < NE; i++) begin
        cfg_a[i] = {1'($urandom % 2), 2'b00, 2'($urandom % 4), 3'($urandom % 8)};
        adr_a[i] = EAW'($urandom % 256);
      end
      sec_mml  = ($urandom % 3) == 0;
      sec_mmwp = ($urandom % 4) == 0;
      check("R11 random", 32'($urandom % 1100), 4'(1 + $urandom % 8),
            3'($urandom % 8), 1'($urandom % 2));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule